// File: doc/BRIEF.md
# Timer Tick-Enable Generator

This block produces one tick-enable strobe per channel for a five-channel PWM timer. Every strobe lives in the base clock domain. Downstream counters advance only in cycles where their strobe is high. No clock is gated or divided.

Two 8-bit prescalers divide the base clock. Channels 0 and 1 share prescaler 0, and channels 2, 3 and 4 share prescaler 1. Each channel then applies its own power-of-two divider to its prescaled ticks. A channel can instead follow an external tick input, which arrives already synchronised as single-cycle pulses.

Software programs the block through a simple write port with two registers. Address 0 holds the two prescaler values. Address 1 holds the five 4-bit channel selectors. A new prescaler value is adopted only when that prescaler wraps, so no tick period is ever cut short.

Top module: `tick_enable_gen`

## Requirements
- R1: Reset clears both configuration registers and holds every `tick_o` bit low. After reset is released, every channel's strobe is high in every cycle from the second cycle onward, which is divide-by-1 on the base clock.
- R2: A prescaler holding value v emits one prescaled tick every v+1 base cycles.
- R3: Channels 0 and 1 count ticks from prescaler 0, and channels 2, 3 and 4 count ticks from prescaler 1.
- R4: A write to address 0 loads prescaler 0 from data bits 7:0 and prescaler 1 from bits 15:8. Bits 31:16 are ignored, and the register holds its value in cycles without a write to it.
- R5: A write to address 1 loads the selector of channel c from data bits 4c+3 down to 4c.
- R6: Selector codes 0 to 4 divide the prescaled tick rate by 2 to the power of the code. The channel strobe is registered, so it follows the prescaled tick that completes its count by one cycle.
- R7: Selector code 5 makes the channel follow an external input, one cycle later. Channels 0 and 1 follow `ext_tick_i[0]`, and channels 2 to 4 follow `ext_tick_i[1]`.
- R8: Selector codes 6 to 15 give divide-by-1 of the prescaled ticks.
- R9: A changed prescaler value takes effect only at that prescaler's next wrap. The period in progress completes at its old length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base timer clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | Register select: 0 prescalers, 1 selectors |
| cfg_wdata | input | 32 | Configuration write data |
| ext_tick_i | input | 2 | Synchronised external tick pulses, one per prescaler group |
| tick_o | output | 5 | Per-channel tick-enable strobes |

## Verification
The timing works as follows:
- A configuration write is visible one cycle after its strobe.
- A prescaled tick appears one cycle after the prescaler's terminal count.
- The channel strobe follows one cycle after that.
- An external pulse reaches its channels one cycle after it is sampled.

A reference model in the bench applies these same delays on every rising edge. The bench compares the outputs against the model at each falling edge, where all outputs are settled. Rate checks count strobes over windows whose length is a multiple of every period involved, so the phase at which a window starts cannot change the expected count. The prescaler-change check measures the gaps between successive channel 0 strobes, starting from a strobe seen before the write.

// File: rtl/tick_gen_pkg.sv
package tick_gen_pkg;

  // Register select on the configuration write port.
  typedef enum logic [0:0] {
    CFG_PRESCALE = 1'b0,
    CFG_SELECT   = 1'b1
  } cfg_addr_e;

  // Index of the prescaler / external source serving a channel.
  function automatic int src_of(input int ch, input int low_group);
    return (ch < low_group) ? 0 : 1;
  endfunction

endpackage

// File: rtl/tick_cfg_regs.sv
module tick_cfg_regs #(
  parameter int DATA_W  = 32,
  parameter int PRE_BITS = 16,
  parameter int SEL_BITS = 20
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we_i,
  input  logic                addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [PRE_BITS-1:0] pre_fields_o,
  output logic [SEL_BITS-1:0] sel_fields_o
);
  import tick_gen_pkg::*;

  logic [PRE_BITS-1:0] pre_q;
  logic [SEL_BITS-1:0] sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
      sel_q <= '0;
    end else if (we_i) begin
      if (addr_i == CFG_PRESCALE) pre_q <= wdata_i[PRE_BITS-1:0];
      else                        sel_q <= wdata_i[SEL_BITS-1:0];
    end
  end

  assign pre_fields_o = pre_q;
  assign sel_fields_o = sel_q;

  // R4: prescaler register keeps its value unless a write to it occurred
  p_pre_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !($past(we_i) && $past(addr_i) == CFG_PRESCALE) |-> $stable(pre_q));

endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PRE_W-1:0] value_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] act_q;
  logic             tick_q;
  logic             wrap;

  assign wrap = (cnt_q == act_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      act_q  <= '0;
      tick_q <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      act_q  <= value_i;
      tick_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_q <= 1'b0;
    end
  end

  assign tick_o = tick_q;

  // R9: counter never runs past the active terminal value
  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= act_q);

  // R9: active value changes only right after a terminal count
  p_reload_at_wrap_r9: assert property (@(posedge clk) disable iff (rst)
    (act_q != $past(act_q)) |-> $past(cnt_q == act_q));

  // R2: a tick is only emitted after a wrap
  p_tick_after_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    tick_q |-> (cnt_q == '0));

endmodule

// File: rtl/tick_chan_div.sv
module tick_chan_div #(
  parameter int SEL_W    = 4,
  parameter int MAX_CODE = 4,
  parameter int EXT_CODE = 5,
  localparam int DCNT_W  = (MAX_CODE < 1) ? 1 : MAX_CODE
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             pre_tick_i,
  input  logic             ext_i,
  output logic             tick_o
);
  logic              is_ext;
  logic [DCNT_W-1:0] lim;
  logic [DCNT_W-1:0] dcnt_q;
  logic              tick_q;

  always_comb begin
    is_ext = (sel_i == SEL_W'(EXT_CODE));
    if (sel_i <= SEL_W'(MAX_CODE)) lim = DCNT_W'((32'd1 << sel_i) - 32'd1);
    else                           lim = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dcnt_q <= '0;
      tick_q <= 1'b0;
    end else if (is_ext) begin
      dcnt_q <= '0;
      tick_q <= ext_i;
    end else if (pre_tick_i) begin
      if (dcnt_q >= lim) begin
        dcnt_q <= '0;
        tick_q <= 1'b1;
      end else begin
        dcnt_q <= dcnt_q + 1'b1;
        tick_q <= 1'b0;
      end
    end else begin
      tick_q <= 1'b0;
    end
  end

  assign tick_o = tick_q;

  // R7: in external mode the strobe is the input delayed one cycle
  p_ext_follow_r7: assert property (@(posedge clk) disable iff (rst)
    $past(is_ext) |-> (tick_o == $past(ext_i)));

  // R6: in divider mode a strobe needs a prescaled tick one cycle earlier
  p_div_needs_pre_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(is_ext) && tick_o) |-> $past(pre_tick_i));

endmodule

// File: rtl/tick_enable_gen.sv
module tick_enable_gen #(
  parameter int NUM_CH    = 5,
  parameter int LOW_GROUP = 2,
  parameter int PRE_W     = 8,
  parameter int SEL_W     = 4,
  parameter int MAX_CODE  = 4,
  parameter int EXT_CODE  = 5,
  parameter int DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [1:0]        ext_tick_i,
  output logic [NUM_CH-1:0] tick_o
);
  import tick_gen_pkg::*;

  localparam int NUM_SRC  = 2;
  localparam int PRE_BITS = NUM_SRC * PRE_W;
  localparam int SEL_BITS = NUM_CH * SEL_W;

  logic [PRE_BITS-1:0] pre_fields;
  logic [SEL_BITS-1:0] sel_fields;
  logic [NUM_SRC-1:0]  pre_tick;

  tick_cfg_regs #(
    .DATA_W  (DATA_W),
    .PRE_BITS(PRE_BITS),
    .SEL_BITS(SEL_BITS)
  ) u_regs (
    .clk         (clk),
    .rst         (rst),
    .we_i        (cfg_we),
    .addr_i      (cfg_addr),
    .wdata_i     (cfg_wdata),
    .pre_fields_o(pre_fields),
    .sel_fields_o(sel_fields)
  );

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_pre
    tick_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk    (clk),
      .rst    (rst),
      .value_i(pre_fields[s*PRE_W +: PRE_W]),
      .tick_o (pre_tick[s])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int SRC = src_of(c, LOW_GROUP);
    tick_chan_div #(
      .SEL_W   (SEL_W),
      .MAX_CODE(MAX_CODE),
      .EXT_CODE(EXT_CODE)
    ) u_div (
      .clk       (clk),
      .rst       (rst),
      .sel_i     (sel_fields[c*SEL_W +: SEL_W]),
      .pre_tick_i(pre_tick[SRC]),
      .ext_i     (ext_tick_i[SRC]),
      .tick_o    (tick_o[c])
    );
  end

  // R1: no strobe leaves the block in the cycle after a reset cycle
  p_quiet_after_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> (tick_o == '0));

endmodule

// File: tb/tick_enable_gen_bench.sv
`timescale 1ns/1ps
module tick_enable_gen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic        cfg_addr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [1:0]  ext_tick_i = '0;
  logic [4:0]  tick_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  tick_enable_gen u_tick_enable_gen (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ext_tick_i(ext_tick_i), .tick_o(tick_o)
  );

  // Behavioural reference model
  int m_reg0, m_reg1;
  int m_pcnt[2], m_pact[2], m_ptick[2];
  int m_dcnt[5], m_tick[5];

  always @(posedge clk) begin
    int n_pcnt[2], n_pact[2], n_ptick[2], n_dcnt[5], n_tick[5];
    cyc++;
    if (rst) begin
      m_reg0 = 0; m_reg1 = 0;
      for (int s = 0; s < 2; s++) begin m_pcnt[s] = 0; m_pact[s] = 0; m_ptick[s] = 0; end
      for (int c = 0; c < 5; c++) begin m_dcnt[c] = 0; m_tick[c] = 0; end
    end else begin
      for (int c = 0; c < 5; c++) begin
        int sel, src, lim;
        sel = (m_reg1 >> (4*c)) & 15;
        src = (c < 2) ? 0 : 1;
        n_dcnt[c] = m_dcnt[c];
        if (sel == 5) begin
          n_dcnt[c] = 0;
          n_tick[c] = ext_tick_i[src];
        end else begin
          lim = (sel <= 4) ? (1 << sel) - 1 : 0;
          n_tick[c] = 0;
          if (m_ptick[src] != 0) begin
            if (m_dcnt[c] >= lim) begin n_dcnt[c] = 0; n_tick[c] = 1; end
            else n_dcnt[c] = m_dcnt[c] + 1;
          end
        end
      end
      for (int s = 0; s < 2; s++) begin
        if (m_pcnt[s] == m_pact[s]) begin
          n_pcnt[s] = 0; n_pact[s] = (m_reg0 >> (8*s)) & 255; n_ptick[s] = 1;
        end else begin
          n_pcnt[s] = m_pcnt[s] + 1; n_pact[s] = m_pact[s]; n_ptick[s] = 0;
        end
      end
      if (cfg_we) begin
        if (cfg_addr == 1'b0) m_reg0 = int'(cfg_wdata[15:0]);
        else                  m_reg1 = int'(cfg_wdata[19:0]);
      end
      for (int s = 0; s < 2; s++) begin
        m_pcnt[s] = n_pcnt[s]; m_pact[s] = n_pact[s]; m_ptick[s] = n_ptick[s];
      end
      for (int c = 0; c < 5; c++) begin m_dcnt[c] = n_dcnt[c]; m_tick[c] = n_tick[c]; end
    end
  end

  // Per-cycle comparison and strobe counters, sampled at the falling edge
  int cnt[5];
  always @(negedge clk) begin
    logic [4:0] exp_v;
    for (int c = 0; c < 5; c++) begin
      exp_v[c] = (m_tick[c] != 0);
      if (tick_o[c]) cnt[c]++;
    end
    checks++;
    if (tick_o !== exp_v) begin
      errors++;
      $display("FAIL %s cycle %0d: tick_o actual %b expected %b", cur_req, cyc, tick_o, exp_v);
    end
  end

  task automatic check_eq(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk); #1;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic clr_counts();
    @(negedge clk); #1;
    for (int c = 0; c < 5; c++) cnt[c] = 0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int times[$];
    // R1: reset state
    repeat (3) @(negedge clk);
    check_eq("R1 reset strobes", int'(tick_o), 0);
    @(negedge clk); #1; rst = 1'b0;
    repeat (3) @(negedge clk);
    clr_counts();
    repeat (20) @(negedge clk); #1;
    for (int c = 0; c < 5; c++) check_eq("R1 default divide-by-1", cnt[c], 20);

    // R2 R3 R4 R5 R6: prescalers 1 and 4, mixed dividers; junk in upper bits
    cur_req = "R6";
    wr(1'b0, 32'hABCD_0401);
    wr(1'b1, {12'h0, 4'd4, 4'd3, 4'd0, 4'd0, 4'd1});
    repeat (100) @(negedge clk);
    clr_counts();
    repeat (400) @(negedge clk); #1;
    check_eq("R2 R3 R4 R5 R6 ch0 pre0 div2", cnt[0], 100);
    check_eq("R2 R3 R4 ch1 pre0 div1", cnt[1], 200);
    check_eq("R2 R3 R4 ch2 pre1 div1", cnt[2], 80);
    check_eq("R5 R6 ch3 div8", cnt[3], 10);
    check_eq("R5 R6 ch4 div16", cnt[4], 5);

    // R7 R8: external sources and codes above the divider range
    cur_req = "R7";
    wr(1'b1, {12'h0, 4'd0, 4'd15, 4'd5, 4'd7, 4'd5});
    repeat (20) @(negedge clk);
    clr_counts();
    for (int i = 0; i < 200; i++) begin
      ext_tick_i[0] = (i % 20 == 3) && (i < 140);
      ext_tick_i[1] = (i % 50 == 10) && (i < 150);
      @(negedge clk); #1;
    end
    ext_tick_i = '0;
    check_eq("R7 ch0 follows ext0", cnt[0], 7);
    check_eq("R7 ch2 follows ext1", cnt[2], 3);
    check_eq("R8 ch1 code7 divide-by-1", cnt[1], 100);
    check_eq("R8 ch3 code15 divide-by-1", cnt[3], 40);
    check_eq("R3 ch4 on pre1", cnt[4], 40);

    // R9: prescaler change completes the period in progress
    cur_req = "R9";
    wr(1'b0, 32'h0000_0009);
    wr(1'b1, 32'h0);
    repeat (40) @(negedge clk);
    while (!tick_o[0]) @(negedge clk);
    times.push_back(cyc);
    repeat (4) @(negedge clk);
    #1; cfg_we = 1'b1; cfg_addr = 1'b0; cfg_wdata = 32'h0000_0002;
    @(negedge clk);
    if (tick_o[0]) times.push_back(cyc);
    #1; cfg_we = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (tick_o[0]) times.push_back(cyc);
    end
    check_eq("R9 strobes seen", (times.size() >= 4) ? 1 : 0, 1);
    if (times.size() >= 4) begin
      check_eq("R9 old period completes", times[1] - times[0], 10);
      check_eq("R9 new period", times[2] - times[1], 3);
      check_eq("R9 new period steady", times[3] - times[2], 3);
    end

    done = 1;
    finish_run();
  end
endmodule